// File: doc/BRIEF.md
# Flash Status Polling Bit Generator

This block forms the word a NOR-style flash returns to the host on each read while an embedded program or erase runs. During such an operation the host keeps reading and learns progress from a few bits of the read word, not from array contents. Bit 7 carries a data-poll value. Bit 6 flips on every read. Bit 5 reports a timeout. Bit 3 reports a programming voltage too low to finish the job. Bit 2 flips on reads of a sector whose erase has been suspended. With the device idle and no fault held, the stored array word passes through unchanged.

The read word is registered, so the word for the inputs seen at one clock edge appears after that edge. A read is counted on the rising edge of the read strobe only, so a strobe held high for several clocks counts once. Fault bits stay set after the operation ends and clear only on the accepted reset command. The array itself, the program and erase pulse machinery and the pin-level bus timing are outside this block.

Top module: `flash_status_gen`

## Requirements
- R1: While `rst` is high, the next clock edge loads `rd_word` with zero, and both fault latches and both toggle bits return to 0.
- R2: In idle mode (`busy` low, no fault latched, `susp` low), `rd_word` equals the `array_data` value of the previous clock.
- R3: In status mode with `op_erase` = 0 (program), `rd_word[7]` is the complement of `wr_poll_bit`.
- R4: In status mode with `op_erase` = 1 (erase), `rd_word[7]` is 0.
- R5: Status mode is `busy` high or any fault latched. In that mode, each rising edge of `rd_stb` inverts `rd_word[6]` on the second clock after the edge. Holding `rd_stb` high does not invert it again.
- R6: A cycle with `op_start` high clears both toggle bits (`rd_word[6]` and `rd_word[2]`) to 0, and no read counts in that cycle.
- R7: `tmo_err` high while `busy` is high sets a latch shown at `rd_word[5]`. The latch stays set, and the block stays in status mode, after `busy` falls.
- R8: `vpp_low` high while `busy` is high sets a latch shown at `rd_word[3]`, held like R7.
- R9: `reset_cmd` high clears both fault latches and wins over a set in the same cycle. Once cleared and not busy, the block returns to R2 behaviour.
- R10: Outside status mode, with `susp` high and `sec_hit` high, `rd_word` is 0 except bit 7 = 1 and bit 2. Bit 2 inverts once per rising edge of `rd_stb`. With `sec_hit` low, `rd_word` follows R2.
- R11: In status mode, all bits of `rd_word` other than 7, 6, 5, 3 and 2 are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | One-cycle pulse when a program or erase begins |
| busy | input | 1 | An embedded operation is running |
| op_erase | input | 1 | 1 = erase, 0 = program |
| wr_poll_bit | input | 1 | Bit 7 of the word being programmed |
| susp | input | 1 | An erase is suspended |
| sec_hit | input | 1 | The current read address lies in the suspended sector |
| vpp_low | input | 1 | Programming voltage below the usable level |
| tmo_err | input | 1 | Operation exceeded its internal time limit |
| reset_cmd | input | 1 | Reset command accepted; clears fault latches |
| rd_stb | input | 1 | Host read strobe, counted on its rising edge |
| array_data | input | DATA_W | Stored array word at the read address |
| rd_word | output | DATA_W | Registered read word returned to the host |

## Verification
A toggle bit that is out of step is the hardest fault to catch here. It shows as bit 6 or bit 2 holding its value across one read, or flipping twice, and it is visible within two clocks of a strobe edge. A fault latch that drops early is visible on the next clock, because the word falls back to array data while the host still expects status. A latch that fails to clear is visible the same way once the reset command is sent. The bench's reference model is compared on every clock, so any such drift is reported in the cycle it first reaches `rd_word`.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  // Bit positions of the status word; the host decodes these, so they are fixed.
  localparam int POLL_BIT = 7;
  localparam int TOG_BIT  = 6;
  localparam int ERR_BIT  = 5;
  localparam int VPP_BIT  = 3;
  localparam int STOG_BIT = 2;

  // Fault latch slots
  localparam int FLT_ERR = 0;
  localparam int FLT_VPP = 1;
  localparam int FLT_N   = 2;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_STATUS = 2'd1,
    MODE_SUSRD  = 2'd2
  } rd_mode_e;
endpackage

// File: rtl/flash_edge_toggle.sv
module flash_edge_toggle (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic rise,
  input  logic en,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= 1'b0;
    else if (rise && en) q <= ~q;
  end
endmodule

// File: rtl/flash_fault_latch.sv
module flash_fault_latch #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [N-1:0] set,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clr) q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/flash_status_mux.sv
module flash_status_mux
  import flash_status_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  rd_mode_e          mode,
  input  logic              op_erase,
  input  logic              wr_poll_bit,
  input  logic              tog,
  input  logic              stog,
  input  logic              err,
  input  logic              vpp,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] word
);
  always_comb begin
    word = '0;
    unique case (mode)
      MODE_STATUS: begin
        word[POLL_BIT] = op_erase ? 1'b0 : ~wr_poll_bit;
        word[TOG_BIT]  = tog;
        word[ERR_BIT]  = err;
        word[VPP_BIT]  = vpp;
        word[STOG_BIT] = stog;
      end
      MODE_SUSRD: begin
        word[POLL_BIT] = 1'b1;
        word[STOG_BIT] = stog;
      end
      default: word = array_data;
    endcase
  end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_status_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_start,
  input  logic              busy,
  input  logic              op_erase,
  input  logic              wr_poll_bit,
  input  logic              susp,
  input  logic              sec_hit,
  input  logic              vpp_low,
  input  logic              tmo_err,
  input  logic              reset_cmd,
  input  logic              rd_stb,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_word
);
  logic              rd_q;
  logic              rd_rise;
  logic [FLT_N-1:0]  fault_set;
  logic [FLT_N-1:0]  fault_q;
  logic              err_q;
  logic              vpp_q;
  logic              tog_q;
  logic              stog_q;
  logic              stat_mode;
  logic              sus_read;
  rd_mode_e          mode;
  logic [DATA_W-1:0] word_d;

  always_ff @(posedge clk) begin
    if (rst) rd_q <= 1'b0;
    else     rd_q <= rd_stb;
  end
  assign rd_rise = rd_stb & ~rd_q;

  assign fault_set[FLT_ERR] = busy & tmo_err;
  assign fault_set[FLT_VPP] = busy & vpp_low;

  flash_fault_latch #(.N(FLT_N)) u_fault (
    .clk(clk), .rst(rst), .clr(reset_cmd), .set(fault_set), .q(fault_q)
  );
  assign err_q = fault_q[FLT_ERR];
  assign vpp_q = fault_q[FLT_VPP];

  assign stat_mode = busy | err_q | vpp_q;
  assign sus_read  = ~stat_mode & susp & sec_hit;

  always_comb begin
    if (stat_mode)     mode = MODE_STATUS;
    else if (sus_read) mode = MODE_SUSRD;
    else               mode = MODE_IDLE;
  end

  flash_edge_toggle u_tog (
    .clk(clk), .rst(rst), .clr(op_start), .rise(rd_rise), .en(stat_mode), .q(tog_q)
  );
  flash_edge_toggle u_stog (
    .clk(clk), .rst(rst), .clr(op_start), .rise(rd_rise), .en(sus_read), .q(stog_q)
  );

  flash_status_mux #(.DATA_W(DATA_W)) u_mux (
    .mode(mode), .op_erase(op_erase), .wr_poll_bit(wr_poll_bit),
    .tog(tog_q), .stog(stog_q), .err(err_q), .vpp(vpp_q),
    .array_data(array_data), .word(word_d)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_word <= '0;
    else     rd_word <= word_d;
  end
endmodule

// File: rtl/flash_status_chk.sv
module flash_status_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              op_erase,
  input logic              wr_poll_bit,
  input logic              susp,
  input logic              reset_cmd,
  input logic [DATA_W-1:0] array_data,
  input logic [DATA_W-1:0] rd_word,
  input logic              err_q,
  input logic              vpp_q
);
  AST_RST_CLEARS_WORD: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> rd_word == '0); // R1

  AST_IDLE_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !busy && !err_q && !vpp_q && !susp) |-> rd_word == $past(array_data)); // R2

  AST_PROG_POLL: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && busy && !op_erase) |-> rd_word[7] == !$past(wr_poll_bit)); // R3

  AST_ERASE_POLL: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && busy && op_erase) |-> !rd_word[7]); // R4

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && err_q && !reset_cmd) |-> err_q); // R7

  AST_VPP_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && vpp_q && !reset_cmd) |-> vpp_q); // R8

  AST_CMD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && reset_cmd) |-> (!err_q && !vpp_q)); // R9

  AST_HIGH_BYTE_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && busy) |-> rd_word[DATA_W-1:8] == '0); // R11
endmodule

bind flash_status_gen flash_status_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_flash_status_gen.sv
module tb_flash_status_gen;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_start = 0, busy = 0, op_erase = 0, wr_poll_bit = 0;
  logic susp = 0, sec_hit = 0, vpp_low = 0, tmo_err = 0, reset_cmd = 0, rd_stb = 0;
  logic [W-1:0] array_data = '0;
  logic [W-1:0] rd_word;

  int tests = 0;
  int fails = 0;
  string phase = "R1";
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  flash_status_gen #(.DATA_W(W)) dut (
    .clk(clk), .rst(rst), .op_start(op_start), .busy(busy), .op_erase(op_erase),
    .wr_poll_bit(wr_poll_bit), .susp(susp), .sec_hit(sec_hit), .vpp_low(vpp_low),
    .tmo_err(tmo_err), .reset_cmd(reset_cmd), .rd_stb(rd_stb),
    .array_data(array_data), .rd_word(rd_word)
  );

  // Behavioural reference model
  logic [W-1:0] exp_word = '0;
  bit m_tog, m_stog, m_err, m_vpp, m_prev;
  bit model_ok = 0;

  always @(posedge clk) begin
    bit stat, rise;
    logic [W-1:0] w;
    if (rst) begin
      exp_word = '0; m_tog = 0; m_stog = 0; m_err = 0; m_vpp = 0; m_prev = 0;
      model_ok = 1;
    end else begin
      stat = busy || m_err || m_vpp;
      rise = rd_stb && !m_prev;
      w = '0;
      if (stat) begin
        w[7] = op_erase ? 1'b0 : !wr_poll_bit;
        w[6] = m_tog; w[5] = m_err; w[3] = m_vpp; w[2] = m_stog;
      end else if (susp && sec_hit) begin
        w[7] = 1'b1; w[2] = m_stog;
      end else begin
        w = array_data;
      end
      exp_word = w;
      if (op_start) begin
        m_tog = 0; m_stog = 0;
      end else if (rise) begin
        if (stat) m_tog = !m_tog;
        else if (susp && sec_hit) m_stog = !m_stog;
      end
      if (reset_cmd) begin
        m_err = 0; m_vpp = 0;
      end else if (busy) begin
        if (tmo_err) m_err = 1;
        if (vpp_low) m_vpp = 1;
      end
      m_prev = rd_stb;
    end
  end

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (model_ok && !rst && !done) check(phase, rd_word, exp_word);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read();
    rd_stb = 1; cyc(3); rd_stb = 0; cyc(2);
  endtask

  task automatic summary();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic b6;
    cyc(3);
    // R1: reset state
    phase = "R1";
    check("R1", rd_word, '0);
    rst = 0; cyc(1);
    check("R1", rd_word, '0);

    // R2: idle pass-through
    phase = "R2";
    array_data = 16'hA5C3; cyc(1);
    check("R2", rd_word, 16'hA5C3);
    array_data = 16'h1234; cyc(1);
    check("R2", rd_word, 16'h1234);

    // R3: program polling
    phase = "R3";
    op_start = 1; busy = 1; op_erase = 0; wr_poll_bit = 1; cyc(1);
    op_start = 0; cyc(1);
    check("R3", {15'd0, rd_word[7]}, 16'd0);
    wr_poll_bit = 0; cyc(1);
    check("R3", {15'd0, rd_word[7]}, 16'd1);

    // R5: toggle per strobe edge, held strobe counts once
    phase = "R5";
    b6 = rd_word[6];
    check("R5", {15'd0, b6}, 16'd0);
    rd_stb = 1; cyc(2);
    check("R5", {15'd0, rd_word[6]}, 16'd1);
    cyc(4);
    check("R5", {15'd0, rd_word[6]}, 16'd1);
    rd_stb = 0; cyc(2);
    do_read();
    check("R5", {15'd0, rd_word[6]}, 16'd0);
    do_read();
    check("R11", rd_word & ~16'h00EC, 16'h0000);

    // R6: new operation clears toggle
    phase = "R6";
    op_start = 1; rd_stb = 1; cyc(1);
    op_start = 0; cyc(1);
    check("R6", {15'd0, rd_word[6]}, 16'd0);
    rd_stb = 0; cyc(2);
    check("R6", {15'd0, rd_word[6]}, 16'd0);

    // R4: erase polling
    phase = "R4";
    op_erase = 1; wr_poll_bit = 0; cyc(2);
    check("R4", {15'd0, rd_word[7]}, 16'd0);

    // R7: timeout latch
    phase = "R7";
    tmo_err = 1; cyc(1); tmo_err = 0; cyc(1);
    check("R7", {15'd0, rd_word[5]}, 16'd1);
    busy = 0; cyc(3);
    check("R7", {15'd0, rd_word[5]}, 16'd1);
    do_read();
    check("R11", rd_word & ~16'h00EC, 16'h0000);

    // R9: reset command
    phase = "R9";
    reset_cmd = 1; cyc(1); reset_cmd = 0; cyc(1);
    check("R9", rd_word, 16'h1234);

    // R8: VPP latch, and R9 clear priority over a same-cycle set
    phase = "R8";
    op_start = 1; busy = 1; op_erase = 0; wr_poll_bit = 1; cyc(1);
    op_start = 0; vpp_low = 1; cyc(1); vpp_low = 0; cyc(1);
    check("R8", {15'd0, rd_word[3]}, 16'd1);
    busy = 0; cyc(2);
    check("R8", {15'd0, rd_word[3]}, 16'd1);
    phase = "R9";
    busy = 1; tmo_err = 1; reset_cmd = 1; cyc(1);
    tmo_err = 0; reset_cmd = 0; busy = 0; cyc(2);
    check("R9", rd_word, 16'h1234);

    // R10: suspended-sector reads
    phase = "R10";
    susp = 1; sec_hit = 1; cyc(2);
    check("R10", rd_word, 16'h0080);
    do_read();
    check("R10", rd_word, 16'h0084);
    rd_stb = 1; cyc(5); rd_stb = 0; cyc(2);
    check("R10", rd_word, 16'h0080);
    sec_hit = 0; array_data = 16'hBEEF; cyc(1);
    check("R10", rd_word, 16'hBEEF);
    do_read();
    sec_hit = 1; cyc(1);
    check("R10", rd_word, 16'h0080);
    susp = 0; sec_hit = 0; cyc(2);

    phase = "R1";
    rst = 1; cyc(2);
    check("R1", rd_word, '0);
    rst = 0; cyc(2);
    summary();
  end
endmodule